// File: doc/BRIEF.md
# Flash Read-Map Mode Controller

This block is a synchronous model of the logic that decides what a parallel NOR-style flash returns on each read. A host drives a word-addressed bus with separate read and write strobes. Writes are decoded as one-byte commands taken from the low byte of the write data. Reads come back as a registered word one clock after the strobe. Four read maps exist: plain array reads, data polling while a program runs, a one-shot status overlay, and an identification table overlay. An embedded program algorithm runs beside these maps and can be idle, busy or suspended.

The behaviour is built from a mode state machine, a busy timer that stands in for the program algorithm, and a small backing array. The mode states are `MODE_ARRAY`, `MODE_POLL`, `MODE_SR` and `MODE_ASO`; the algorithm states are `ALG_IDLE`, `ALG_BUSY` and `ALG_SUSP`. The mode transitions are:
- ARRAY→ASO on 0x90, and ASO→ARRAY on 0xF0.
- any non-SR mode→SR on 0x70, and SR→saved mode on the next read.
- ARRAY→POLL when the data write that follows 0xA0 arrives, or on 0x30 while suspended.
- POLL→ARRAY on 0xB0, which suspends the program, or when the program completes.

The algorithm moves IDLE→BUSY on program start, BUSY→SUSP on 0xB0, SUSP→BUSY on 0x30, and BUSY→IDLE on completion.

Top module: `flash_aso_ctrl`

## Requirements
- R1: After reset `rdata` is 0x0000, the map is array read, the algorithm is idle and every array word reads 0xFFFF. A reset asserted mid-run returns to this same state.
- R2: In array mode a read returns the stored word. After command 0x90, a read at word index i below ID_DEPTH returns 0xC000+i, and a read at any other address returns the filler word FILL_WORD (default 0xA5A5).
- R3: The identification overlay is left only by 0xF0. Commands 0xA0, 0x30 and 0xB0 written inside it have no effect.
- R4: Command 0x70 is accepted in every mode except the status overlay. The next read, at any address, returns the status word, and the following reads use the mode that was active when 0x70 was written.
- R5: While the status overlay is active, every write, including 0xF0 and 0x70, is ignored.
- R6: In array mode with the algorithm idle, 0xA0 followed by one write (address, data) starts a program. Until completion a read at any address returns a word whose bit 7 is the inverse of data bit 7 and whose other bits are 0. The read captured BUSY_CYCLES+1 clocks after the data write is the last polling read. After completion the map is array read and the word holds old AND new.
- R7: The status word has bit 7 = ready (algorithm not busy), bit 6 = suspended and bit 4 = program failed; all other bits are 0. The fail bit is set when a program asks to turn a 0 into a 1, and it is cleared when the next program starts.
- R8: 0xB0 while a program is busy suspends it. The map becomes array read, the status reads 0x00C0 and array words can be read. While suspended, 0xA0 is ignored. 0x30 resumes the program into polling, and the program then completes normally.
- R9: While the algorithm is busy, only 0x70 and 0xB0 have any effect. In particular 0xF0 does not abort the program.
- R10: When read and write strobes are both high in one cycle, the read is served and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (command or program data) |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; low byte is the command code |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |

## Verification
The hardest state to reach is a status overlay that was entered from polling and left in the same cycle as the program completes. Here the saved return mode must turn into array read rather than polling. The bench reaches its neighbours by timing reads against the known completion cycle. It reads exactly at the last polling cycle and then at the first array cycle after a data write. It also enters the overlay from polling, reads the status and confirms the return to polling. The suspended path is reached by writing 0xB0 a few cycles into a program, then trying 0xA0 and 0x30 from there.

// File: rtl/flash_aso_pkg.sv
package flash_aso_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_POLL,
        MODE_SR,
        MODE_ASO
    } map_mode_e;

    typedef enum logic [1:0] {
        ALG_IDLE,
        ALG_BUSY,
        ALG_SUSP
    } alg_state_e;

    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'h30;

    function automatic logic [WORD_W-1:0] ident_word(input int unsigned idx);
        return 16'hC000 + 16'(idx);
    endfunction
endpackage

// File: rtl/flash_aso_timer.sv
module flash_aso_timer #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);
endmodule

// File: rtl/flash_aso_store.sv
module flash_aso_store
    import flash_aso_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_fail,
    input  logic              commit,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword,
    output logic              fail
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              fail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
            fail_q <= 1'b0;
        end else begin
            if (clr_fail) begin
                fail_q <= 1'b0;
            end
            if (commit) begin
                mem_q[waddr] <= mem_q[waddr] & wword;
                fail_q       <= |(wword & ~mem_q[waddr]);
            end
        end
    end

    assign rword = mem_q[raddr];
    assign fail  = fail_q;
endmodule

// File: rtl/flash_aso_fsm.sv
module flash_aso_fsm
    import flash_aso_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    output map_mode_e         mode,
    output alg_state_e        alg,
    output logic              start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [WORD_W-1:0] prog_data
);
    map_mode_e         mode_q, mode_n, ret_q, ret_n;
    alg_state_e        alg_q, alg_n;
    logic              armed_q, armed_n, start_n;
    logic [ADDR_W-1:0] paddr_q;
    logic [WORD_W-1:0] pdata_q;
    logic [7:0]        cmd;
    logic              wr_only;

    assign cmd     = wdata[7:0];
    assign wr_only = wr_en && !rd_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_ARRAY;
            ret_q   <= MODE_ARRAY;
            alg_q   <= ALG_IDLE;
            armed_q <= 1'b0;
            paddr_q <= '0;
            pdata_q <= '0;
        end else begin
            mode_q  <= mode_n;
            ret_q   <= ret_n;
            alg_q   <= alg_n;
            armed_q <= armed_n;
            if (start_n) begin
                paddr_q <= addr;
                pdata_q <= wdata;
            end
        end
    end

    // next-state decode
    always_comb begin
        mode_n  = mode_q;
        ret_n   = ret_q;
        alg_n   = alg_q;
        armed_n = armed_q;
        start_n = 1'b0;
        unique case (mode_q)
            MODE_SR: begin
                if (rd_en) begin
                    mode_n = ret_q;
                end
            end
            default: begin
                if (wr_only) begin
                    if (armed_q) begin
                        start_n = 1'b1;
                        armed_n = 1'b0;
                        alg_n   = ALG_BUSY;
                        mode_n  = MODE_POLL;
                    end else if (cmd == CMD_STATUS) begin
                        ret_n  = mode_q;
                        mode_n = MODE_SR;
                    end else begin
                        unique case (mode_q)
                            MODE_ARRAY: begin
                                if (cmd == CMD_IDENT) begin
                                    mode_n = MODE_ASO;
                                end else if (cmd == CMD_PROG && alg_q == ALG_IDLE) begin
                                    armed_n = 1'b1;
                                end else if (cmd == CMD_RESUME && alg_q == ALG_SUSP) begin
                                    alg_n  = ALG_BUSY;
                                    mode_n = MODE_POLL;
                                end
                            end
                            MODE_ASO: begin
                                if (cmd == CMD_RESET) begin
                                    mode_n = MODE_ARRAY;
                                end
                            end
                            MODE_POLL: begin
                                if (cmd == CMD_SUSP) begin
                                    alg_n  = ALG_SUSP;
                                    mode_n = MODE_ARRAY;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase
        // completion wins over any same-cycle command
        if (done) begin
            alg_n = ALG_IDLE;
            if (mode_n == MODE_POLL) mode_n = MODE_ARRAY;
            if (ret_n == MODE_POLL)  ret_n  = MODE_ARRAY;
        end
    end

    // outputs
    always_comb begin
        mode      = mode_q;
        alg       = alg_q;
        start     = start_n;
        prog_addr = paddr_q;
        prog_data = pdata_q;
    end
endmodule

// File: rtl/flash_aso_ctrl.sv
module flash_aso_ctrl
    import flash_aso_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                ID_DEPTH    = 8,
    parameter int                BUSY_CYCLES = 20,
    parameter logic [WORD_W-1:0] FILL_WORD   = 16'hA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    map_mode_e         mode_q;
    alg_state_e        alg_q;
    logic              prog_start, prog_done, prog_fail;
    logic [ADDR_W-1:0] prog_addr;
    logic [WORD_W-1:0] prog_data, array_word, status_word, read_word;
    logic [WORD_W-1:0] rdata_q;

    flash_aso_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .done     (prog_done),
        .mode     (mode_q),
        .alg      (alg_q),
        .start    (prog_start),
        .prog_addr(prog_addr),
        .prog_data(prog_data)
    );

    flash_aso_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (prog_start),
        .run  (alg_q == ALG_BUSY),
        .done (prog_done)
    );

    flash_aso_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_fail(prog_start),
        .commit  (prog_done),
        .waddr   (prog_addr),
        .wword   (prog_data),
        .raddr   (addr),
        .rword   (array_word),
        .fail    (prog_fail)
    );

    always_comb begin
        status_word    = '0;
        status_word[7] = (alg_q != ALG_BUSY);
        status_word[6] = (alg_q == ALG_SUSP);
        status_word[4] = prog_fail;
    end

    always_comb begin
        read_word = '0;
        unique case (mode_q)
            MODE_ARRAY: read_word = array_word;
            MODE_POLL:  read_word[7] = ~prog_data[7];
            MODE_SR:    read_word = status_word;
            MODE_ASO:   read_word = (int'(addr) < ID_DEPTH) ? ident_word(int'(addr)) : FILL_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= read_word;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/flash_aso_chk.sv
module flash_aso_chk
    import flash_aso_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [WORD_W-1:0] wdata,
    input map_mode_e         mode_q,
    input alg_state_e        alg_q,
    input logic              prog_done
);
    p_sr_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SR && rd_en) |=> (mode_q != MODE_SR));

    p_sr_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SR && !rd_en) |=> (mode_q == MODE_SR));

    p_poll_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_POLL) |-> (alg_q == ALG_BUSY));

    p_busy_shows_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_q == ALG_BUSY && mode_q != MODE_SR) |-> (mode_q == MODE_POLL));

    p_aso_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ASO && !(wr_en && !rd_en && (wdata[7:0] == CMD_RESET || wdata[7:0] == CMD_STATUS)))
        |=> (mode_q == MODE_ASO));

    p_done_idles_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> (alg_q == ALG_IDLE));

    p_read_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ARRAY && rd_en && wr_en) |=> (mode_q == MODE_ARRAY));
endmodule

bind flash_aso_ctrl flash_aso_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .mode_q   (mode_q),
    .alg_q    (alg_q),
    .prog_done(prog_done)
);

// File: tb/flash_aso_ctrl_tb.sv
`timescale 1ns/1ps
module flash_aso_ctrl_tb;
    localparam int          AW   = 6;
    localparam int          IDD  = 8;
    localparam int          NBSY = 20;
    localparam logic [15:0] FILL = 16'hA5A5;
    localparam logic [1:0]  OP_W = 2'd1;
    localparam logic [1:0]  OP_R = 2'd2;
    localparam int          NVEC = 17;

    // {op, req, addr, wdata, expected}
    localparam logic [43:0] VEC [NVEC] = '{
        {OP_R, 4'd1,  6'd0,  16'h0000, 16'hFFFF},  // R1 erased
        {OP_R, 4'd1,  6'd63, 16'h0000, 16'hFFFF},  // R1 erased
        {OP_W, 4'd2,  6'd0,  16'h0090, 16'h0000},
        {OP_R, 4'd2,  6'd0,  16'h0000, 16'hC000},  // R2 ident
        {OP_R, 4'd2,  6'd3,  16'h0000, 16'hC003},  // R2 ident
        {OP_R, 4'd2,  6'd40, 16'h0000, FILL},      // R2 filler
        {OP_W, 4'd3,  6'd0,  16'h00A0, 16'h0000},  // R3 ignored
        {OP_W, 4'd3,  6'd0,  16'h0030, 16'h0000},  // R3 ignored
        {OP_W, 4'd3,  6'd0,  16'h00B0, 16'h0000},  // R3 ignored
        {OP_R, 4'd3,  6'd5,  16'h0000, 16'hC005},  // R3 still ident
        {OP_W, 4'd4,  6'd0,  16'h0070, 16'h0000},
        {OP_W, 4'd5,  6'd0,  16'h00F0, 16'h0000},  // R5 ignored in SR
        {OP_R, 4'd4,  6'd50, 16'h0000, 16'h0080},  // R4 status
        {OP_R, 4'd4,  6'd1,  16'h0000, 16'hC001},  // R4 back to ident
        {OP_W, 4'd3,  6'd0,  16'h00F0, 16'h0000},  // R3 exit
        {OP_R, 4'd3,  6'd1,  16'h0000, 16'hFFFF},  // R3 array again
        {OP_R, 4'd7,  6'd2,  16'h0000, 16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    int            total = 0;
    int            bad = 0;
    logic [15:0]   got;

    always #4 clk = ~clk;

    flash_aso_ctrl #(.ADDR_W(AW), .ID_DEPTH(IDD), .BUSY_CYCLES(NBSY), .FILL_WORD(FILL)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] q);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset rdata", rdata, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][43:42] == OP_W) begin
                wr(VEC[i][37:32], VEC[i][31:16]);
            end else begin
                rd(VEC[i][37:32], got);
                check($sformatf("R%0d vector %0d", VEC[i][41:38], i), got, VEC[i][15:0]);
            end
        end

        // R10: simultaneous strobes, write 0x90 must be dropped
        addr = 6'd0; wdata = 16'h0090; rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 read served", rdata, 16'hFFFF);
        rd(6'd1, got);
        check("R10 write dropped", got, 16'hFFFF);

        // R6: program 0x1234 at 5, exact completion boundary
        wr(6'd0, 16'h00A0);
        wr(6'd5, 16'h1234);
        repeat (NBSY) @(negedge clk);
        rd(6'd9, got);
        check("R6 last poll read", got, 16'h0080);
        rd(6'd5, got);
        check("R6 programmed word", got, 16'h1234);
        wr(6'd0, 16'h0070);
        rd(6'd0, got);
        check("R7 ready no fail", got, 16'h0080);

        // R7 fail: 0x00F0 over 0x1234, R9 reset ignored while busy, R4 SR from poll
        wr(6'd0, 16'h00A0);
        wr(6'd5, 16'h00F0);
        rd(6'd3, got);
        check("R6 poll inverted bit7", got, 16'h0000);
        wr(6'd0, 16'h00F0);
        rd(6'd3, got);
        check("R9 reset ignored while busy", got, 16'h0000);
        wr(6'd0, 16'h0070);
        rd(6'd0, got);
        check("R4 status while busy", got, 16'h0000);
        rd(6'd0, got);
        check("R4 back to polling", got, 16'h0000);
        repeat (NBSY + 4) @(negedge clk);
        rd(6'd5, got);
        check("R6 AND merge", got, 16'h0030);
        wr(6'd0, 16'h0070);
        rd(6'd0, got);
        check("R7 fail bit set", got, 16'h0090);

        // R7 fail cleared by next program
        wr(6'd0, 16'h00A0);
        wr(6'd7, 16'h0F0F);
        repeat (NBSY + 4) @(negedge clk);
        wr(6'd0, 16'h0070);
        rd(6'd0, got);
        check("R7 fail cleared", got, 16'h0080);

        // R8: suspend, blocked program, resume
        wr(6'd0, 16'h00A0);
        wr(6'd9, 16'h5555);
        repeat (3) @(negedge clk);
        wr(6'd0, 16'h00B0);
        wr(6'd0, 16'h0070);
        rd(6'd0, got);
        check("R8 suspended status", got, 16'h00C0);
        rd(6'd7, got);
        check("R8 array readable", got, 16'h0F0F);
        wr(6'd0, 16'h00A0);
        wr(6'd11, 16'h0000);
        rd(6'd11, got);
        check("R8 program blocked", got, 16'hFFFF);
        wr(6'd0, 16'h0070);
        rd(6'd0, got);
        check("R8 still suspended", got, 16'h00C0);
        wr(6'd0, 16'h0030);
        rd(6'd9, got);
        check("R8 resumed polling", got, 16'h0080);
        repeat (NBSY + 4) @(negedge clk);
        rd(6'd9, got);
        check("R8 resumed completes", got, 16'h5555);

        // R1: reset mid-run from the ident overlay
        wr(6'd0, 16'h0090);
        do_reset();
        check("R1 reset clears rdata", rdata, 16'h0000);
        rd(6'd2, got);
        check("R1 array map after reset", got, 16'hFFFF);
        rd(6'd9, got);
        check("R1 array erased after reset", got, 16'hFFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule